// File: doc/BRIEF.md
# Load/Store Byte Lane Formatter

This block sits between the register file and a word-wide data memory port of a 32-bit big-endian RISC core. It is purely combinational. On a load it takes the aligned memory word, the two low address bits and the previous contents of the destination register. From these it forms the value to write back. That covers byte and halfword extraction with sign or zero extension, and the two partial-word merges that place part of an unaligned word into the most significant or least significant end of the register.

On a store it turns the source register value into lane-positioned write data and a per-lane write enable. A misalignment flag reports halfword or word accesses whose address is not naturally aligned. Such an access is suppressed at the ports: nothing is written back and no lane is enabled. Address generation, caching and the exception that the flag would raise are handled elsewhere.

Byte lanes are big-endian. Address offset 0 is the most significant lane, bits 31:24, and its enable is bit 3 of the enable vector. Offset 3 is bits 7:0 and enable bit 0.

Top module: `lsf_lane_fmt`

## Requirements
- R1: The operation code is 4 bits: 1 byte signed load, 2 byte unsigned load, 3 half signed load, 4 half unsigned load, 5 word load, 6 left partial load, 7 right partial load, 8 byte store, 9 half store, 10 word store, 11 left partial store, 12 right partial store. Codes 0 and 13 to 15 are no-ops: no write-back, no lane enable, no misalignment flag. A load never enables a lane and a store never requests write-back.
- R2: Byte loads return the byte at the offset (offset 0 = bits 31:24). The signed form copies bit 7 into bits 31:8 (0xFE gives 0xFFFF_FFFE) and the unsigned form zero-fills (0xFE gives 0x0000_00FE).
- R3: Halfword loads return bits 31:16 for offset 0 and bits 15:0 for offset 2, sign-extended for code 3 and zero-extended for code 4.
- R4: An aligned word load returns the memory word unchanged.
- R5: The misalignment flag is high for a halfword load or store with address bit 0 set, and for a word load or store with a nonzero offset. It is never high for byte or partial operations.
- R6: While the misalignment flag is high, write-back is off and all lane enables are 0.
- R7: A left partial load at offset k places memory bytes k..3 into the register from the most significant byte downward. The low k bytes keep their old value.
- R8: A right partial load at offset k places memory bytes 0..k into the low k+1 register bytes, with memory byte k as the least significant byte. The upper bytes keep their old value.
- R9: A byte store replicates source bits 7:0 on every lane and enables only the lane at the offset.
- R10: A halfword store replicates source bits 15:0 on both halves and enables lanes 0..1 for offset 0 or lanes 2..3 for offset 2.
- R11: An aligned word store enables all four lanes with the source word as data.
- R12: A left partial store at offset k writes register bytes from the most significant byte down into lanes k..3 and enables only those lanes.
- R13: A right partial store at offset k writes register bytes ending with the least significant byte into lanes 0..k and enables only those lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Memory operation code (R1) |
| addr_lo_i | input | 2 | Low address bits, byte offset within the word |
| mem_rdata_i | input | 32 | Aligned word read from memory |
| rt_val_i | input | 32 | Old destination value on loads, source value on stores |
| wb_data_o | output | 32 | Value to write back to the register file |
| wb_en_o | output | 1 | Write-back request |
| mem_be_o | output | 4 | Lane write enables, bit 3 = offset 0 |
| mem_wdata_o | output | 32 | Lane-positioned store data |
| misalign_o | output | 1 | Misaligned halfword or word access |

## Verification
The block holds no state, so a wrong lane select, shift amount or merge mask shows on the ports in the same cycle that the faulty combination is applied. There is no latency to wait for. The risk is coverage rather than timing. A swapped lane or an off-by-one keep mask is visible only for particular offsets and byte patterns. Every operation code is therefore applied at every offset with several distinct data patterns, and byte-wise expectations are compared for each one. Suppression of misaligned accesses is checked at the enable and write-back outputs directly.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  typedef enum logic [3:0] {
    MOP_NONE = 4'd0,
    MOP_LDB  = 4'd1,
    MOP_LDBU = 4'd2,
    MOP_LDH  = 4'd3,
    MOP_LDHU = 4'd4,
    MOP_LDW  = 4'd5,
    MOP_LDL  = 4'd6,
    MOP_LDR  = 4'd7,
    MOP_STB  = 4'd8,
    MOP_STH  = 4'd9,
    MOP_STW  = 4'd10,
    MOP_STL  = 4'd11,
    MOP_STR  = 4'd12
  } mem_op_e;

  function automatic logic op_is_load(input mem_op_e op);
    return (op >= MOP_LDB) && (op <= MOP_LDR);
  endfunction

  function automatic logic op_is_store(input mem_op_e op);
    return (op >= MOP_STB) && (op <= MOP_STR);
  endfunction

endpackage

// File: rtl/lsf_align_chk.sv
module lsf_align_chk
  import lsf_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int OW = $clog2(NBYTES)
) (
  input  mem_op_e       op_i,
  input  logic [OW-1:0] ofs_i,
  output logic          misalign_o
);

  logic half_op;
  logic word_op;

  always_comb begin
    half_op    = (op_i == MOP_LDH) || (op_i == MOP_LDHU) || (op_i == MOP_STH);
    word_op    = (op_i == MOP_LDW) || (op_i == MOP_STW);
    misalign_o = (half_op && ofs_i[0]) || (word_op && (ofs_i != '0));
  end

  always_comb begin
    if (op_i == MOP_LDB || op_i == MOP_LDBU || op_i == MOP_STB ||
        op_i == MOP_LDL || op_i == MOP_LDR  || op_i == MOP_STL || op_i == MOP_STR) begin
      AST_NO_FLAG_BYTE_PART: assert (!misalign_o) else $error("flag on byte/partial op"); // R5
    end
  end

endmodule

// File: rtl/lsf_load_path.sv
module lsf_load_path
  import lsf_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OW = $clog2(NB),
  localparam int HB = NB / 2
) (
  input  mem_op_e         op_i,
  input  logic [OW-1:0]   ofs_i,
  input  logic [XLEN-1:0] rdata_i,
  input  logic [XLEN-1:0] old_i,
  output logic [XLEN-1:0] result_o
);

  logic [OW-1:0]   lane_b;
  logic [OW-2:0]   hlane;
  logic [7:0]      sel_byte;
  logic [15:0]     sel_half;
  logic [XLEN-1:0] lwl_sh;
  logic [XLEN-1:0] lwr_sh;
  logic [XLEN-1:0] lwl_res;
  logic [XLEN-1:0] lwr_res;

  always_comb begin
    lane_b   = OW'(NB - 1) - ofs_i;
    hlane    = (OW-1)'(HB - 1) - ofs_i[OW-1:1];
    sel_byte = rdata_i[8*lane_b +: 8];
    sel_half = rdata_i[16*hlane +: 16];
    lwl_sh   = rdata_i << (8 * ofs_i);
    lwr_sh   = rdata_i >> (8 * lane_b);
  end

  for (genvar j = 0; j < NB; j++) begin : g_lane
    always_comb begin
      lwl_res[8*j +: 8] = (OW'(j) >= ofs_i) ? lwl_sh[8*j +: 8] : old_i[8*j +: 8];
      lwr_res[8*j +: 8] = (OW'(j) <= ofs_i) ? lwr_sh[8*j +: 8] : old_i[8*j +: 8];
    end
  end

  always_comb begin
    case (op_i)
      MOP_LDB:  result_o = {{(XLEN-8){sel_byte[7]}}, sel_byte};
      MOP_LDBU: result_o = {{(XLEN-8){1'b0}}, sel_byte};
      MOP_LDH:  result_o = {{(XLEN-16){sel_half[15]}}, sel_half};
      MOP_LDHU: result_o = {{(XLEN-16){1'b0}}, sel_half};
      MOP_LDW:  result_o = rdata_i;
      MOP_LDL:  result_o = lwl_res;
      MOP_LDR:  result_o = lwr_res;
      default:  result_o = '0;
    endcase
  end

  always_comb begin
    if (op_i == MOP_LDBU) begin
      AST_BYTE_ZERO_FILL: assert (result_o[XLEN-1:8] == '0) else $error("zero fill"); // R2
    end
    if (op_i == MOP_LDL) begin
      AST_LEFT_KEEPS_LOW: assert (((result_o ^ old_i) & ((XLEN'(1) << (8*ofs_i)) - XLEN'(1))) == '0) else $error("left keep"); // R7
    end
    if (op_i == MOP_LDR) begin
      AST_RIGHT_KEEPS_HIGH: assert (((result_o ^ old_i) >> (8*ofs_i) >> 8) == '0) else $error("right keep"); // R8
    end
  end

endmodule

// File: rtl/lsf_store_path.sv
module lsf_store_path
  import lsf_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OW = $clog2(NB),
  localparam int HB = NB / 2
) (
  input  mem_op_e         op_i,
  input  logic [OW-1:0]   ofs_i,
  input  logic [XLEN-1:0] src_i,
  output logic [NB-1:0]   be_o,
  output logic [XLEN-1:0] wdata_o
);

  logic [OW-1:0] lane_b;
  logic [OW-2:0] hlane;
  logic [NB-1:0] be_b;
  logic [NB-1:0] be_h;
  logic [NB-1:0] be_l;
  logic [NB-1:0] be_r;

  always_comb begin
    lane_b = OW'(NB - 1) - ofs_i;
    hlane  = (OW-1)'(HB - 1) - ofs_i[OW-1:1];
  end

  for (genvar j = 0; j < NB; j++) begin : g_lane
    always_comb begin
      be_b[j] = (OW'(j) == lane_b);
      be_h[j] = ((OW-1)'(j / 2) == hlane);
      be_l[j] = (OW'(j) <= lane_b);
      be_r[j] = (OW'(j) >= lane_b);
    end
  end

  always_comb begin
    case (op_i)
      MOP_STB: begin
        be_o    = be_b;
        wdata_o = {NB{src_i[7:0]}};
      end
      MOP_STH: begin
        be_o    = be_h;
        wdata_o = {HB{src_i[15:0]}};
      end
      MOP_STW: begin
        be_o    = '1;
        wdata_o = src_i;
      end
      MOP_STL: begin
        be_o    = be_l;
        wdata_o = src_i >> (8 * ofs_i);
      end
      MOP_STR: begin
        be_o    = be_r;
        wdata_o = src_i << (8 * lane_b);
      end
      default: begin
        be_o    = '0;
        wdata_o = '0;
      end
    endcase
  end

  always_comb begin
    if (op_i == MOP_STB) begin
      AST_BYTE_ONE_LANE: assert ($onehot(be_o)) else $error("byte lanes"); // R9
    end
    if (op_i == MOP_STL) begin
      AST_LEFT_LANE_COUNT: assert ($countones(be_o) == NB - int'(ofs_i)) else $error("left lanes"); // R12
    end
    if (op_i == MOP_STR) begin
      AST_RIGHT_LANE_COUNT: assert ($countones(be_o) == int'(ofs_i) + 1) else $error("right lanes"); // R13
    end
  end

endmodule

// File: rtl/lsf_lane_fmt.sv
module lsf_lane_fmt
  import lsf_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int NB = XLEN / 8,
  localparam int OW = $clog2(NB)
) (
  input  logic [3:0]      op_i,
  input  logic [OW-1:0]   addr_lo_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic [XLEN-1:0] rt_val_i,
  output logic [XLEN-1:0] wb_data_o,
  output logic            wb_en_o,
  output logic [NB-1:0]   mem_be_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            misalign_o
);

  mem_op_e       op;
  logic          mis;
  logic [NB-1:0] be_raw;

  assign op = mem_op_e'(op_i);

  lsf_align_chk #(.NBYTES(NB)) align_i (
    .op_i       (op),
    .ofs_i      (addr_lo_i),
    .misalign_o (mis)
  );

  lsf_load_path #(.XLEN(XLEN)) load_i (
    .op_i     (op),
    .ofs_i    (addr_lo_i),
    .rdata_i  (mem_rdata_i),
    .old_i    (rt_val_i),
    .result_o (wb_data_o)
  );

  lsf_store_path #(.XLEN(XLEN)) store_i (
    .op_i    (op),
    .ofs_i   (addr_lo_i),
    .src_i   (rt_val_i),
    .be_o    (be_raw),
    .wdata_o (mem_wdata_o)
  );

  always_comb begin
    misalign_o = mis;
    wb_en_o    = op_is_load(op) && !mis;
    mem_be_o   = mis ? '0 : be_raw;
  end

  always_comb begin
    AST_NO_LOAD_AND_STORE: assert (!(wb_en_o && (mem_be_o != '0))) else $error("both"); // R1
    if (misalign_o) begin
      AST_MISALIGN_QUIET: assert (!wb_en_o && (mem_be_o == '0)) else $error("not quiet"); // R6
    end
  end

endmodule

// File: tb/lsf_lane_fmt_tb.sv
module lsf_lane_fmt_tb_top;

  logic        clk;
  logic [3:0]  op;
  logic [1:0]  ofs;
  logic [31:0] mem;
  logic [31:0] rv;
  logic [31:0] wb;
  logic        wbe;
  logic [3:0]  be;
  logic [31:0] wd;
  logic        mis;

  int  n_chk;
  int  n_err;
  bit  done;

  lsf_lane_fmt dut_i (
    .op_i(op), .addr_lo_i(ofs), .mem_rdata_i(mem), .rt_val_i(rv),
    .wb_data_o(wb), .wb_en_o(wbe), .mem_be_o(be), .mem_wdata_o(wd), .misalign_o(mis)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: op, offset, memory word, register word, expected value, expected enables, requirement
  localparam int NT = 14;
  localparam logic [113:0] TBL [NT] = '{
    {4'd1,  2'd1, 32'h80FE7F01, 32'h0,        32'hFFFFFFFE, 4'b0000, 8'd2},  // R2 signed byte
    {4'd2,  2'd1, 32'h80FE7F01, 32'h0,        32'h000000FE, 4'b0000, 8'd2},  // R2 unsigned byte
    {4'd1,  2'd0, 32'h80FE7F01, 32'h0,        32'hFFFFFF80, 4'b0000, 8'd2},  // R2 offset 0 is MSB
    {4'd1,  2'd2, 32'h80FE7F01, 32'h0,        32'h0000007F, 4'b0000, 8'd2},  // R2 positive byte
    {4'd3,  2'd0, 32'h80FE7F01, 32'h0,        32'hFFFF80FE, 4'b0000, 8'd3},  // R3 upper half
    {4'd4,  2'd2, 32'h80FE7F01, 32'h0,        32'h00007F01, 4'b0000, 8'd3},  // R3 lower half
    {4'd7,  2'd0, 32'h11223344, 32'hAABBCCDD, 32'hAABBCC11, 4'b0000, 8'd8},  // R8
    {4'd7,  2'd2, 32'h11223344, 32'hAABBCCDD, 32'hAA112233, 4'b0000, 8'd8},  // R8
    {4'd6,  2'd1, 32'h11223344, 32'hAABBCCDD, 32'h223344DD, 4'b0000, 8'd7},  // R7
    {4'd6,  2'd3, 32'h11223344, 32'hAABBCCDD, 32'h44BBCCDD, 4'b0000, 8'd7},  // R7
    {4'd11, 2'd1, 32'h0,        32'h11223344, 32'h00112233, 4'b0111, 8'd12}, // R12
    {4'd12, 2'd2, 32'h0,        32'h11223344, 32'h22334400, 4'b1110, 8'd13}, // R13
    {4'd8,  2'd2, 32'h0,        32'h11223344, 32'h44444444, 4'b0010, 8'd9},  // R9
    {4'd9,  2'd2, 32'h0,        32'h11223344, 32'h33443344, 4'b0011, 8'd10}  // R10
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5:       return "R4";
      4'd6:       return "R7";
      4'd7:       return "R8";
      4'd8:       return "R9";
      4'd9:       return "R10";
      4'd10:      return "R11";
      4'd11:      return "R12";
      4'd12:      return "R13";
      default:    return "R1";
    endcase
  endfunction

  // independent byte-wise model; index 0 is offset 0 / most significant byte
  task automatic model(input logic [3:0] o, input logic [1:0] k, input logic [31:0] m, input logic [31:0] r,
                       output logic e_wbe, output logic e_mis, output logic [31:0] e_wb,
                       output logic [3:0] e_be, output logic [31:0] e_wd);
    logic [7:0] mb [4];
    logic [7:0] rb [4];
    logic [7:0] ob [4];
    logic [7:0] wb_b [4];
    int kk;
    kk = int'(k);
    for (int i = 0; i < 4; i++) begin
      mb[i] = m[31-8*i -: 8];
      rb[i] = r[31-8*i -: 8];
      ob[i] = rb[i];
      wb_b[i] = 8'h00;
    end
    e_wb = 32'h0; e_be = 4'b0; e_wd = 32'h0; e_wbe = 1'b0;
    e_mis = ((o == 4'd3 || o == 4'd4 || o == 4'd9) && k[0]) || ((o == 4'd5 || o == 4'd10) && k != 2'd0);
    case (o)
      4'd1: e_wb = {{24{mb[kk][7]}}, mb[kk]};
      4'd2: e_wb = {24'h0, mb[kk]};
      4'd3: e_wb = {{16{mb[kk&2][7]}}, mb[kk&2], mb[(kk&2)+1]};
      4'd4: e_wb = {16'h0, mb[kk&2], mb[(kk&2)+1]};
      4'd5: e_wb = m;
      4'd6: begin
        for (int i = 0; i < 4; i++) if (i >= kk) ob[i-kk] = mb[i];
        e_wb = {ob[0], ob[1], ob[2], ob[3]};
      end
      4'd7: begin
        for (int i = 0; i < 4; i++) if (i <= kk) ob[3-kk+i] = mb[i];
        e_wb = {ob[0], ob[1], ob[2], ob[3]};
      end
      4'd8: begin
        e_be[3-kk] = 1'b1;
        e_wd = {4{rb[3]}};
      end
      4'd9: begin
        e_be = k[1] ? 4'b0011 : 4'b1100;
        e_wd = {2{rb[2], rb[3]}};
      end
      4'd10: begin
        e_be = 4'b1111;
        e_wd = r;
      end
      4'd11: begin
        for (int i = 0; i < 4; i++) if (i >= kk) begin e_be[3-i] = 1'b1; wb_b[i] = rb[i-kk]; end
        e_wd = {wb_b[0], wb_b[1], wb_b[2], wb_b[3]};
      end
      4'd12: begin
        for (int i = 0; i < 4; i++) if (i <= kk) begin e_be[3-i] = 1'b1; wb_b[i] = rb[3-kk+i]; end
        e_wd = {wb_b[0], wb_b[1], wb_b[2], wb_b[3]};
      end
      default: ;
    endcase
    e_wbe = (o >= 4'd1 && o <= 4'd7) && !e_mis;
    if (e_mis) e_be = 4'b0;
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    logic ewbe, emis;
    logic [31:0] ewb, ewd;
    logic [3:0] ebe;
    n_chk = 0; n_err = 0; done = 1'b0;
    pats[0] = 32'h80FE7F01; pats[1] = 32'h11223344; pats[2] = 32'hFFFFFFFF; pats[3] = 32'h0F5AA5F0;
    op = 4'd0; ofs = 2'd0; mem = 32'h12345678; rv = 32'h9ABCDEF0;

    // idle state after start: no-op code does nothing (R1)
    @(negedge clk);
    chk("R1", "idle wb_en", {31'h0, wbe}, 32'h0);
    chk("R1", "idle be", {28'h0, be}, 32'h0);
    chk("R1", "idle misalign", {31'h0, mis}, 32'h0);

    // vector table
    for (int t = 0; t < NT; t++) begin
      @(posedge clk);
      op  = TBL[t][113:110];
      ofs = TBL[t][109:108];
      mem = TBL[t][107:76];
      rv  = TBL[t][75:44];
      @(negedge clk);
      if (TBL[t][113:110] >= 4'd8) begin
        chk($sformatf("R%0d", TBL[t][7:0]), "table be", {28'h0, be}, {28'h0, TBL[t][11:8]});
        chk($sformatf("R%0d", TBL[t][7:0]), "table wdata", wd & lane_mask(TBL[t][11:8]), TBL[t][43:12] & lane_mask(TBL[t][11:8]));
        chk("R1", "table store wb_en", {31'h0, wbe}, 32'h0);
      end else begin
        chk($sformatf("R%0d", TBL[t][7:0]), "table wb", wb, TBL[t][43:12]);
        chk("R1", "table load be", {28'h0, be}, 32'h0);
      end
    end

    // sweep: every code, every offset, several data patterns
    for (int o = 0; o < 16; o++) begin
      for (int k = 0; k < 4; k++) begin
        for (int p = 0; p < 4; p++) begin
          @(posedge clk);
          op = 4'(o); ofs = 2'(k); mem = pats[p]; rv = pats[(p + 1) % 4];
          model(4'(o), 2'(k), pats[p], pats[(p + 1) % 4], ewbe, emis, ewb, ebe, ewd);
          @(negedge clk);
          chk("R5", $sformatf("misalign op=%0d k=%0d", o, k), {31'h0, mis}, {31'h0, emis});
          chk(emis ? "R6" : req_of(4'(o)), $sformatf("wb_en op=%0d k=%0d", o, k), {31'h0, wbe}, {31'h0, ewbe});
          chk(emis ? "R6" : req_of(4'(o)), $sformatf("be op=%0d k=%0d", o, k), {28'h0, be}, {28'h0, ebe});
          if (ewbe) chk(req_of(4'(o)), $sformatf("wb op=%0d k=%0d", o, k), wb, ewb);
          if (ebe != 4'b0) chk(req_of(4'(o)), $sformatf("wdata op=%0d k=%0d", o, k), wd & lane_mask(ebe), ewd & lane_mask(ebe));
        end
      end
    end

    // directed corners: misaligned half and word are suppressed (R5, R6)
    @(posedge clk); op = 4'd9; ofs = 2'd3; rv = 32'hCAFEBABE;
    @(negedge clk);
    chk("R6", "misaligned half store be", {28'h0, be}, 32'h0);
    chk("R5", "misaligned half store flag", {31'h0, mis}, 32'h1);
    @(posedge clk); op = 4'd5; ofs = 2'd2; mem = 32'hDEADBEEF;
    @(negedge clk);
    chk("R6", "misaligned word load wb_en", {31'h0, wbe}, 32'h0);
    @(posedge clk); op = 4'd10; ofs = 2'd0; rv = 32'hCAFEBABE;
    @(negedge clk);
    chk("R11", "aligned word store data", wd, 32'hCAFEBABE);
    chk("R11", "aligned word store be", {28'h0, be}, 32'hF);
    @(posedge clk); op = 4'd5; ofs = 2'd0;
    @(negedge clk);
    chk("R4", "aligned word load", wb, 32'hDEADBEEF);
    @(posedge clk); op = 4'd15; ofs = 2'd1;
    @(negedge clk);
    chk("R1", "unused code be", {28'h0, be}, 32'h0);
    chk("R1", "unused code wb_en", {31'h0, wbe}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule